// File: doc/BRIEF.md
# Cascaded Maskable Interrupt Controller

This block gathers up to fifteen device interrupt request lines and presents them to a processor as one interrupt output. It is built from two eight-line controller slices. The secondary slice does not drive the processor: its combined request appears on line 2 of the primary slice. Only the primary slice's summary drives the output pin.

Each request input passes through a two-flop synchroniser. A rising edge then latches a pending bit. The pending bit is kept even while the line is masked, so a request made during masking is delivered as soon as the mask bit is cleared. Among the eligible lines (pending and unmasked), the lowest-numbered one wins. The secondary slice as a whole competes at position 2 of the primary slice, and its own lowest eligible line is chosen inside it.

A one-cycle acknowledge clears the pending bit of the winning line. It also loads an 8-bit vector equal to that slice's programmable base plus the line index. Software reads and writes the mask and status of either slice through a small register port.

Top module: `irq_merge_ctrl`

## Requirements
- R1: After reset both mask registers read 0xFF, both status registers read 0x00, `irq_o` is low and `vec_o` is 0x00.
- R2: A rising edge on a request input sets that line's pending bit; the bit appears in the slice status on the third rising clock edge after the input rises. This happens whether or not the line is masked.
- R3: `irq_o` is high exactly when at least one primary line is pending and unmasked. A pending line that was masked raises `irq_o` in the cycle after its mask bit is cleared.
- R4: Register port encoding is as follows. `reg_slice_i` = 0 selects the primary slice and 1 selects the secondary slice. `reg_kind_i` = 0 selects the mask and 1 selects the status. Bit k of each register belongs to line k of that slice. A mask write takes effect at the next clock edge, a write with `reg_kind_i` = 1 changes nothing, and `reg_rdata_o` follows the selection combinationally.
- R5: Among eligible lines the lowest index wins. The secondary slice competes at primary position 2, and ties inside it go to its lowest eligible line.
- R6: An acknowledge while `irq_o` is high clears only the winner's pending bit. It loads `vec_o` with `base_pri_i` + index for a primary winner, or `base_sec_i` + index for a secondary winner, with 8-bit wrap-around.
- R7: An acknowledge while `irq_o` is low changes neither `vec_o` nor any pending bit.
- R8: Request input bit 2 is ignored. Primary status bit 2 reads 1 when the secondary slice has an unmasked pending line. Setting primary mask bit 2 blocks the whole secondary slice.
- R9: A pending bit is cleared only by an acknowledge that selects it. Masking a line does not clear it.
- R10: Request inputs 0–7 map to primary lines 0–7, and inputs 8–15 map to secondary lines 0–7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Device request lines (bits 0–7 primary, 8–15 secondary, bit 2 unused) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_slice_i | input | 1 | Slice select (0 primary, 1 secondary) |
| reg_kind_i | input | 1 | Register select (0 mask, 1 status) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| base_pri_i | input | 8 | Vector base for primary lines |
| base_sec_i | input | 8 | Vector base for secondary lines |
| ack_i | input | 1 | One-cycle interrupt acknowledge |
| irq_o | output | 1 | Interrupt request to processor |
| vec_o | output | 8 | Vector of the last acknowledged line |

## Verification
The assertions assume two things about the inputs. First, the acknowledge is a single-cycle pulse. Second, a request input stays at each level long enough for the synchroniser to see it, so a pending bit drops only through a selected acknowledge.

The stimulus respects both. It holds every request level for four cycles before releasing it and leaves four more cycles before the next edge. It issues acknowledges only as isolated one-cycle pulses. The mask-write checks rely on writes being separated by at least one cycle, and the stimulus never writes on consecutive cycles.

// File: rtl/irqm_pkg.sv
`timescale 1ns/1ps
package irqm_pkg;
  localparam int SLICE_LINES = 8;
  localparam int VEC_W       = 8;
  localparam int CASC_POS    = 2;
  localparam int SYNC_DEPTH  = 2;

  typedef enum logic {
    KIND_MASK   = 1'b0,
    KIND_STATUS = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/irqm_sync.sv
`timescale 1ns/1ps
module irqm_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  always_comb begin
    stg_d[0] = async_i;
    for (int k = 1; k < DEPTH; k++) stg_d[k] = stg_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stg_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) stg_q[k] <= stg_d[k];
    end
  end

  assign rise_o = stg_q[STAGES-1] & ~stg_q[STAGES];
endmodule

// File: rtl/irqm_slice.sv
`timescale 1ns/1ps
module irqm_slice #(
  parameter int N        = 8,
  parameter bit CASC_EN  = 1'b0,
  parameter int CASC_IDX = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         set_i,
  input  logic                 casc_i,
  input  logic                 mask_we_i,
  input  logic [N-1:0]         mask_wd_i,
  input  logic                 take_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] win_o,
  output logic [N-1:0]         status_o,
  output logic [N-1:0]         mask_o
);
  localparam int IW = $clog2(N);
  localparam logic [N-1:0] CASC_BIT = CASC_EN ? (N'(1) << CASC_IDX) : '0;

  logic [N-1:0]  mask_q, pend_q, pend_d;
  logic [N-1:0]  eff, elig, clr;
  logic [IW-1:0] win;

  // cascade position carries the live level from the lower slice
  assign eff  = pend_q | (casc_i ? CASC_BIT : '0);
  assign elig = eff & ~mask_q;

  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) win = IW'(i);
    end
  end

  always_comb begin
    clr = '0;
    if (take_i && (|elig)) clr[win] = 1'b1;
    pend_d = (pend_q & ~clr) | (set_i & ~CASC_BIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_we_i) begin
      mask_q <= mask_wd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign any_o    = |elig;
  assign win_o    = win;
  assign status_o = eff;
  assign mask_o   = mask_q;
endmodule

// File: rtl/irq_merge_ctrl.sv
`timescale 1ns/1ps
module irq_merge_ctrl
  import irqm_pkg::*;
#(
  parameter int LINES     = SLICE_LINES,
  parameter int VW        = VEC_W,
  parameter int CASC_LINE = CASC_POS,
  parameter int SYNC_STG  = SYNC_DEPTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*LINES-1:0] req_i,
  input  logic               reg_wr_i,
  input  logic               reg_slice_i,
  input  logic               reg_kind_i,
  input  logic [LINES-1:0]   reg_wdata_i,
  output logic [LINES-1:0]   reg_rdata_o,
  input  logic [VW-1:0]      base_pri_i,
  input  logic [VW-1:0]      base_sec_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [VW-1:0]      vec_o
);
  localparam int IW = $clog2(LINES);

  logic [2*LINES-1:0] rise;
  logic               pri_any, sec_any;
  logic [IW-1:0]      pri_win, sec_win;
  logic [LINES-1:0]   pri_stat, sec_stat, pri_mask, sec_mask;
  logic               pri_mwe, sec_mwe;
  logic               ack_fire, casc_sel, pri_take, sec_take;
  logic [VW-1:0]      vec_q, vec_d;
  reg_kind_e          kind;

  irqm_sync #(.W(2*LINES), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (req_i),
    .rise_o  (rise)
  );

  assign kind    = reg_kind_e'(reg_kind_i);
  assign pri_mwe = reg_wr_i && !reg_slice_i && (kind == KIND_MASK);
  assign sec_mwe = reg_wr_i &&  reg_slice_i && (kind == KIND_MASK);

  assign ack_fire = ack_i && pri_any;
  assign casc_sel = (pri_win == IW'(CASC_LINE));
  assign pri_take = ack_fire && !casc_sel;
  assign sec_take = ack_fire &&  casc_sel;

  irqm_slice #(.N(LINES), .CASC_EN(1'b0), .CASC_IDX(CASC_LINE)) u_sec (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (rise[2*LINES-1:LINES]),
    .casc_i    (1'b0),
    .mask_we_i (sec_mwe),
    .mask_wd_i (reg_wdata_i),
    .take_i    (sec_take),
    .any_o     (sec_any),
    .win_o     (sec_win),
    .status_o  (sec_stat),
    .mask_o    (sec_mask)
  );

  irqm_slice #(.N(LINES), .CASC_EN(1'b1), .CASC_IDX(CASC_LINE)) u_pri (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (rise[LINES-1:0]),
    .casc_i    (sec_any),
    .mask_we_i (pri_mwe),
    .mask_wd_i (reg_wdata_i),
    .take_i    (pri_take),
    .any_o     (pri_any),
    .win_o     (pri_win),
    .status_o  (pri_stat),
    .mask_o    (pri_mask)
  );

  always_comb begin
    vec_d = vec_q;
    if (ack_fire) begin
      if (casc_sel) vec_d = base_sec_i + VW'(sec_win);
      else          vec_d = base_pri_i + VW'(pri_win);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (ack_fire) begin
      vec_q <= vec_d;
    end
  end

  always_comb begin
    unique case ({reg_slice_i, kind == KIND_STATUS})
      2'b00:   reg_rdata_o = pri_mask;
      2'b01:   reg_rdata_o = pri_stat;
      2'b10:   reg_rdata_o = sec_mask;
      default: reg_rdata_o = sec_stat;
    endcase
  end

  assign irq_o = pri_any;
  assign vec_o = vec_q;
endmodule

// File: rtl/irqm_chk.sv
`timescale 1ns/1ps
module irqm_chk #(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_i,
  input logic          irq_o,
  input logic [VW-1:0] vec_o,
  input logic          reg_wr_i,
  input logic          reg_slice_i,
  input logic          reg_kind_i,
  input logic [N-1:0]  reg_wdata_i,
  input logic [N-1:0]  pri_stat,
  input logic [N-1:0]  sec_stat,
  input logic [N-1:0]  pri_mask
);
  logic [N-1:0]   pri_keep;
  logic [2*N-1:0] all_pend;
  assign pri_keep = pri_stat & ~(N'(1) << 2);
  assign all_pend = {sec_stat, pri_keep};

  // R3
  irq_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pri_stat & ~pri_mask) != '0));

  // R7
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o) |=> $stable(vec_o));

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> ((all_pend & $past(all_pend)) == $past(all_pend)));

  // R6
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> ($countones($past(all_pend) & ~all_pend) <= 1));

  // R4
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !reg_slice_i && !reg_kind_i) |=> (pri_mask == $past(reg_wdata_i)));
endmodule

bind irq_merge_ctrl irqm_chk #(.N(LINES), .VW(VW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack_i       (ack_i),
  .irq_o       (irq_o),
  .vec_o       (vec_o),
  .reg_wr_i    (reg_wr_i),
  .reg_slice_i (reg_slice_i),
  .reg_kind_i  (reg_kind_i),
  .reg_wdata_i (reg_wdata_i),
  .pri_stat    (pri_stat),
  .sec_stat    (sec_stat),
  .pri_mask    (pri_mask)
);

// File: tb/test_irq_merge_ctrl.sv
`timescale 1ns/1ps
module test_irq_merge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        reg_wr = 1'b0, reg_slice = 1'b0, reg_kind = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  base_pri = 8'h20, base_sec = 8'hFC;
  logic        ack = 1'b0;
  logic        irq;
  logic [7:0]  vec;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_merge_ctrl i_irq_merge_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .reg_wr_i(reg_wr),
    .reg_slice_i(reg_slice), .reg_kind_i(reg_kind), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .base_pri_i(base_pri), .base_sec_i(base_sec),
    .ack_i(ack), .irq_o(irq), .vec_o(vec)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic s, logic k, logic [7:0] d);
    reg_slice = s; reg_kind = k; wdata = d; reg_wr = 1'b1;
    cyc(1);
    reg_wr = 1'b0;
    cyc(1);
  endtask

  task automatic rd(logic s, logic k, output logic [7:0] d);
    reg_slice = s; reg_kind = k;
    #0.5;
    d = rdata;
  endtask

  task automatic pulse(logic [15:0] bits);
    req = bits;
    cyc(4);
    req = '0;
    cyc(4);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
  endtask

  function automatic int key(int l);
    return (l < 8) ? l * 8 : 16 + (l - 8);
  endfunction

  function automatic logic [7:0] vexp(int l);
    return (l < 8) ? 8'(base_pri + 8'(l)) : 8'(base_sec + 8'(l - 8));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    rd(0, 0, d); check("R1 pri mask", d, 8'hFF);
    rd(1, 0, d); check("R1 sec mask", d, 8'hFF);
    rd(0, 1, d); check("R1 pri status", d, 8'h00);
    rd(1, 1, d); check("R1 sec status", d, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 vec", vec, 8'h00);

    // R2 latency and capture while masked
    req[5] = 1'b1;
    @(posedge clk); @(posedge clk);
    #1 rd(0, 1, d); check("R2 not yet at edge 2", d, 8'h00);
    @(posedge clk);
    #1 rd(0, 1, d); check("R2 set at edge 3", d, 8'h20);
    cyc(2); req = '0; cyc(4);
    check("R3 masked no irq", irq, 0);
    // R7 ack with irq low
    do_ack();
    check("R7 vec unchanged", vec, 8'h00);
    rd(0, 1, d); check("R7 status unchanged", d, 8'h20);
    // R4 write to status ignored
    wr(0, 1, 8'hFF);
    rd(0, 1, d); check("R4 status write ignored", d, 8'h20);
    rd(0, 0, d); check("R4 mask unchanged by status write", d, 8'hFF);
    // R3 unmask delivers
    wr(0, 0, 8'hDF);
    check("R3 irq after unmask", irq, 1);
    // R9 re-mask keeps pending
    wr(0, 0, 8'hFF);
    check("R3 irq off when masked", irq, 0);
    rd(0, 1, d); check("R9 pending kept", d, 8'h20);
    wr(0, 0, 8'h00);
    do_ack();
    check("R6 vec line5", vec, 8'h25);
    check("R6 irq cleared", irq, 0);
    rd(0, 1, d); check("R6 status cleared", d, 8'h00);

    // R8 input bit 2 ignored
    pulse(16'h0004);
    rd(0, 1, d); check("R8 bit2 ignored status", d, 8'h00);
    check("R8 bit2 ignored irq", irq, 0);

    // R8 primary mask bit 2 gates secondary
    wr(1, 0, 8'h00);
    wr(0, 0, 8'h04);
    pulse(16'h0800);
    rd(1, 1, d); check("R10 sec line3 pending", d, 8'h08);
    check("R8 cascade masked irq", irq, 0);
    rd(0, 1, d); check("R8 pri status bit2", d, 8'h04);
    wr(0, 0, 8'h00);
    check("R8 cascade unmasked irq", irq, 1);
    do_ack();
    check("R6 sec vec", vec, 8'hFF);

    // R5/R6/R10 single-line sweep
    for (int l = 0; l < 16; l++) begin
      if (l == 2) continue;
      pulse(16'(1) << l);
      check($sformatf("R3 irq line%0d", l), irq, 1);
      do_ack();
      check($sformatf("R6 R10 vec line%0d", l), vec, vexp(l));
      check($sformatf("R6 irq off line%0d", l), irq, 0);
    end

    // R5 pairwise priority sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        int w, o;
        if (a == 2 || b == 2) continue;
        w = (key(a) < key(b)) ? a : b;
        o = (w == a) ? b : a;
        pulse((16'(1) << a) | (16'(1) << b));
        do_ack();
        check($sformatf("R5 first of %0d,%0d", a, b), vec, vexp(w));
        check($sformatf("R6 irq remains %0d,%0d", a, b), irq, 1);
        do_ack();
        check($sformatf("R5 second of %0d,%0d", a, b), vec, vexp(o));
        check($sformatf("R6 drained %0d,%0d", a, b), irq, 0);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule